// File: doc/BRIEF.md
# Real-Time Linear Interpolating Upsampler

This block raises the rate of a stereo stream of 16-bit signed two's-complement audio samples so that a converter running without an oversampling filter sees a smoother staircase. Each time a new input pair arrives, the block draws a straight line from the previously received sample to the new one. On every output-rate tick it emits the next point of that line, for the left channel and then for the right. A configuration input picks eight or sixteen output points per input period. The output word carries four fractional bits, so every point on the line is exact and the last step lands on the target with no drift.

There is no block buffering. The delay is one input period: the interpolation always heads toward the most recently received sample. Ticks are expected to arrive at the output rate, spaced at least two clock cycles apart. The source keeps a tick and an input strobe out of the same cycle. If that happens anyway, the load wins: the tick emits the value held before the load and does not advance the line.

Top module: `lin_upsampler`

## Requirements
- R1: After reset no output is produced: `out_valid_o` stays 0, and ticks are ignored until the first `in_valid_i`. The interpolation start points reset to zero, so the first period ramps from 0 toward the first sample.
- R2: `ratio16_i` = 0 selects 8 output points per input period: the start point plus 7 intermediates. `ratio16_i` = 1 selects 16 points: the start point plus 15 intermediates.
- R3: Point k of a period (k = 0 for the first tick after a load) equals 16·base + k·(target − base)·16/N. Here N is the ratio and the value is read as a 20-bit signed number scaled by 16. The line reaches exactly 16·target after N steps.
- R4: In 8x mode bit 0 of every output word is 0, so the word carries 19 significant bits.
- R5: A tick produces the left value on the next cycle with `out_right_o` = 0. It produces the right value on the cycle after that with `out_right_o` = 1.
- R6: Left and right channels are interpolated independently, each from its own base and target.
- R7: Ticks beyond N within one input period repeat 16·target and never overshoot.
- R8: A new sample becomes the target; the first tick after a load outputs the previous target (one input period of delay).
- R9: `ratio16_i` is sampled only when `in_valid_i` is high. A change between samples has no effect until the next load, and each load restarts the step count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio16_i | input | 1 | 1 = 16x, 0 = 8x; sampled with in_valid_i |
| in_valid_i | input | 1 | New input sample pair strobe |
| in_left_i | input | 16 | Left input sample, signed |
| in_right_i | input | 16 | Right input sample, signed |
| tick_i | input | 1 | Output-rate tick |
| out_valid_o | output | 1 | Output word valid |
| out_right_o | output | 1 | 0 = left word, 1 = right word |
| out_data_o | output | 20 | Interpolated sample, signed, 4 fractional bits |

## Verification
The line is tried with a slow ramp whose deltas do not divide evenly by the ratio. This separates exact fixed-point stepping from truncated per-step increments. Full-scale jumps from the maximum positive to the maximum negative value and back in 16x mode expose overflow in the difference or the accumulator. A repeated constant input separates a flat hold from a stale or drifting accumulator. Extra ticks past the end of a period, and a ratio flip in the middle of a period, show whether the line holds at its target and whether the mode is latched only at the sample boundary. Different values on the two channels show whether they are mixed up.

// File: rtl/lin_up_pkg.sv
package lin_up_pkg;
  localparam int SAMPLE_W = 16;
  localparam int FRAC_W   = 4;
  localparam int NUM_CH   = 2;

  typedef enum logic {
    RATIO_X8  = 1'b0,
    RATIO_X16 = 1'b1
  } ratio_e;
endpackage

// File: rtl/lin_step_ctrl.sv
module lin_step_ctrl
  import lin_up_pkg::*;
#(
  parameter int FRAC_W = lin_up_pkg::FRAC_W,
  localparam int CNT_W = FRAC_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic             ratio16_i,
  output logic             fine_o,
  output logic             started_o,
  output logic             adv_o,
  output logic             emit_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST_FINE   = CNT_W'(1) << FRAC_W;
  localparam logic [CNT_W-1:0] LAST_COARSE = CNT_W'(1) << (FRAC_W - 1);

  ratio_e           mode_q;
  logic             started_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last      = (mode_q == RATIO_X16) ? LAST_FINE : LAST_COARSE;
  assign emit_o    = tick_i & started_q;
  assign adv_o     = emit_o & ~load_i & (cnt_q != last);
  assign fine_o    = (mode_q == RATIO_X16);
  assign started_o = started_q;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= RATIO_X8;
      started_q <= 1'b0;
      cnt_q     <= '0;
    end else if (load_i) begin
      mode_q    <= ratio16_i ? RATIO_X16 : RATIO_X8;
      started_q <= 1'b1;
      cnt_q     <= '0;
    end else if (adv_o) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/lin_chan_interp.sv
module lin_chan_interp #(
  parameter int SAMPLE_W = lin_up_pkg::SAMPLE_W,
  parameter int FRAC_W   = lin_up_pkg::FRAC_W,
  localparam int OUT_W   = SAMPLE_W + FRAC_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic                       adv_i,
  input  logic                       fine_i,
  output logic signed [OUT_W-1:0]    acc_o,
  output logic signed [SAMPLE_W-1:0] target_o
);
  logic signed [SAMPLE_W-1:0] base_q, target_q;
  logic signed [OUT_W-1:0]    acc_q, diff, inc;

  // difference of two 16-bit values needs 17 bits; 8x step needs 18
  assign diff = OUT_W'(target_q) - OUT_W'(base_q);
  assign inc  = fine_i ? diff : (diff <<< 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      target_q <= '0;
      acc_q    <= '0;
    end else if (load_i) begin
      base_q   <= target_q;
      target_q <= sample_i;
      acc_q    <= {target_q, {FRAC_W{1'b0}}};
    end else if (adv_i) begin
      acc_q <= acc_q + inc;
    end
  end

  assign acc_o    = acc_q;
  assign target_o = target_q;
endmodule

// File: rtl/lin_out_serial.sv
module lin_out_serial #(
  parameter int OUT_W = lin_up_pkg::SAMPLE_W + lin_up_pkg::FRAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             emit_i,
  input  logic [OUT_W-1:0] left_i,
  input  logic [OUT_W-1:0] right_i,
  output logic             valid_o,
  output logic             right_o,
  output logic [OUT_W-1:0] data_o
);
  logic [OUT_W-1:0] hold_q;
  logic             pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      pend_q  <= 1'b0;
      valid_o <= 1'b0;
      right_o <= 1'b0;
      data_o  <= '0;
    end else if (emit_i) begin
      data_o  <= left_i;
      hold_q  <= right_i;
      valid_o <= 1'b1;
      right_o <= 1'b0;
      pend_q  <= 1'b1;
    end else if (pend_q) begin
      data_o  <= hold_q;
      valid_o <= 1'b1;
      right_o <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      right_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lin_upsampler.sv
module lin_upsampler
  import lin_up_pkg::*;
#(
  parameter int SAMPLE_W = lin_up_pkg::SAMPLE_W,
  parameter int FRAC_W   = lin_up_pkg::FRAC_W,
  localparam int OUT_W   = SAMPLE_W + FRAC_W,
  localparam int CNT_W   = FRAC_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ratio16_i,
  input  logic                in_valid_i,
  input  logic [SAMPLE_W-1:0] in_left_i,
  input  logic [SAMPLE_W-1:0] in_right_i,
  input  logic                tick_i,
  output logic                out_valid_o,
  output logic                out_right_o,
  output logic [OUT_W-1:0]    out_data_o
);
  logic                       fine, started, adv, emit;
  logic [CNT_W-1:0]           step_cnt;
  logic signed [SAMPLE_W-1:0] samp_w [NUM_CH];
  logic signed [OUT_W-1:0]    acc_w  [NUM_CH];
  logic signed [SAMPLE_W-1:0] tgt_w  [NUM_CH];

  assign samp_w[0] = in_left_i;
  assign samp_w[1] = in_right_i;

  lin_step_ctrl #(.FRAC_W(FRAC_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (in_valid_i),
    .tick_i   (tick_i),
    .ratio16_i(ratio16_i),
    .fine_o   (fine),
    .started_o(started),
    .adv_o    (adv),
    .emit_o   (emit),
    .cnt_o    (step_cnt)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    lin_chan_interp #(.SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (in_valid_i),
      .sample_i(samp_w[ch]),
      .adv_i   (adv),
      .fine_i  (fine),
      .acc_o   (acc_w[ch]),
      .target_o(tgt_w[ch])
    );
  end

  lin_out_serial #(.OUT_W(OUT_W)) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .emit_i (emit),
    .left_i (acc_w[0]),
    .right_i(acc_w[1]),
    .valid_o(out_valid_o),
    .right_o(out_right_o),
    .data_o (out_data_o)
  );
endmodule

// File: rtl/lin_upsampler_chk.sv
module lin_upsampler_chk #(
  parameter int SAMPLE_W = 16,
  parameter int FRAC_W   = 4,
  localparam int OUT_W   = SAMPLE_W + FRAC_W,
  localparam int CNT_W   = FRAC_W + 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                in_valid_i,
  input logic                out_valid_o,
  input logic                out_right_o,
  input logic                fine_i,
  input logic                started_i,
  input logic [CNT_W-1:0]    step_cnt_i,
  input logic [OUT_W-1:0]    acc_l_i,
  input logic [SAMPLE_W-1:0] tgt_l_i
);
  logic             seen_q;
  logic [CNT_W-1:0] last;

  assign last = fine_i ? (CNT_W'(1) << FRAC_W) : (CNT_W'(1) << (FRAC_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else if (in_valid_i) seen_q <= 1'b1;
  end

  a_r1_no_out_before_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> seen_q);

  a_r1_start_tracks_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_i == seen_q);

  a_r5_left_then_right: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_right_o) |=> (out_valid_o && out_right_o));

  a_r5_right_after_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_right_o) |-> $past(out_valid_o && !out_right_o));

  a_r7_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_cnt_i <= last);

  a_r3_lands_on_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_cnt_i == last) |-> (acc_l_i == {tgt_l_i, {FRAC_W{1'b0}}}));
endmodule

bind lin_upsampler lin_upsampler_chk #(.SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .out_valid_o(out_valid_o),
  .out_right_o(out_right_o),
  .fine_i     (fine),
  .started_i  (started),
  .step_cnt_i (step_cnt),
  .acc_l_i    (acc_w[0]),
  .tgt_l_i    (tgt_w[0])
);

// File: tb/lin_upsampler_tb.sv
`timescale 1ns/1ps
module lin_upsampler_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ratio16 = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_l = '0, in_r = '0;
  logic        tick = 1'b0;
  logic        out_valid, out_right;
  logic [19:0] out_data;

  int checks = 0;
  int errors = 0;
  int outs   = 0;

  // reference model state
  int  base_m[2] = '{0, 0};
  int  tgt_m[2]  = '{0, 0};
  int  k_m       = 0;
  bit  mode_m    = 1'b0;
  bit  started_m = 1'b0;

  int    exp_val[$];
  bit    exp_ch[$];
  bit    exp_m8[$];
  string exp_tag[$];

  always #2.5 clk = ~clk;

  lin_upsampler u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ratio16_i  (ratio16),
    .in_valid_i (in_valid),
    .in_left_i  (in_l),
    .in_right_i (in_r),
    .tick_i     (tick),
    .out_valid_o(out_valid),
    .out_right_o(out_right),
    .out_data_o (out_data)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(int l, int r, bit m);
    @(negedge clk);
    ratio16  = m;
    in_valid = 1'b1;
    in_l     = 16'(l);
    in_r     = 16'(r);
    base_m[0] = tgt_m[0]; tgt_m[0] = l;
    base_m[1] = tgt_m[1]; tgt_m[1] = r;
    mode_m = m; k_m = 0; started_m = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic tick_once(string tag);
    int n;
    @(negedge clk);
    tick = 1'b1;
    if (started_m) begin
      n = mode_m ? 16 : 8;
      for (int ch = 0; ch < 2; ch++) begin
        exp_val.push_back(base_m[ch] * 16 + k_m * (tgt_m[ch] - base_m[ch]) * (16 / n));
        exp_ch.push_back(ch[0]);
        exp_m8.push_back(!mode_m);
        exp_tag.push_back(tag);
      end
      if (k_m < n) k_m++;
    end
    @(negedge clk);
    tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ticks(int cnt, string tag);
    for (int i = 0; i < cnt; i++) tick_once(tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      outs++;
      if (exp_val.size() == 0) begin
        check(1'b0, "R1 unexpected output", int'($signed(out_data)), 0);
      end else begin
        int    ev;
        bit    ec, em8;
        string et;
        ev = exp_val.pop_front(); ec = exp_ch.pop_front();
        em8 = exp_m8.pop_front(); et = exp_tag.pop_front();
        check(int'($signed(out_data)) == ev, et, int'($signed(out_data)), ev);
        check(out_right == ec, "R5 channel order", int'(out_right), int'(ec));
        if (em8) check(out_data[0] == 1'b0, "R4 8x lsb", int'(out_data[0]), 0);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: ticks before the first sample are ignored
        ticks(2, "R1 pre-input tick");
        check(outs == 0, "R1 outputs before input", outs, 0);
        // R1 R8 R2: first period ramps from zero, 8x
        load(1000, -1000, 1'b0);
        ticks(8, "R8 R1 first period from zero");
        // R3 R6: ramp with deltas not divisible by the ratio
        load(1013, -1003, 1'b0);
        ticks(8, "R3 R6 ramp 8x");
        // R7: extra ticks hold target
        ticks(3, "R7 hold at target");
        // R2 R3: full-scale jumps 16x
        load(32767, -32768, 1'b1);
        ticks(16, "R2 R3 settle 16x");
        load(-32768, 32767, 1'b1);
        ticks(16, "R3 full-scale down/up 16x");
        load(32767, -32768, 1'b1);
        ticks(17, "R3 R7 full-scale up/down 16x");
        // constant input
        load(32767, -32768, 1'b0);
        ticks(8, "R3 constant 8x");
        load(-5, 7, 1'b0);
        ticks(8, "R6 R4 8x step");
        // R9: mid-period ratio flip has no effect
        load(300, -301, 1'b0);
        ticks(3, "R9 before flip");
        @(negedge clk) ratio16 = 1'b1;
        ticks(6, "R9 after flip stays 8x");
        load(-1234, 4321, 1'b1);
        ticks(16, "R9 R2 new ratio at boundary");
        repeat (6) @(negedge clk);
        check(exp_val.size() == 0, "R5 all outputs seen", exp_val.size(), 0);
        check(outs == 2 * (8 + 8 + 3 + 16 + 16 + 17 + 8 + 8 + 9 + 16),
              "R2 output count", outs,
              2 * (8 + 8 + 3 + 16 + 16 + 17 + 8 + 8 + 9 + 16));
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R5 watchdog actual=hung expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule